// File: doc/BRIEF.md
# Three-Decade Decimal Event Counter

This block counts high-to-low transitions on a count line that is not tied to the core clock. It keeps the running total as three binary-coded-decimal digits: ones, tens and hundreds. The count line first passes through a short synchronizer chain. An edge detector then turns each high-to-low transition into a single one-cycle advance request. The three decades are cascaded synchronously on the system clock. A carry never ripples across clock cycles, so every digit of a new total appears in the same cycle.

A hold input blocks counting without disturbing the stored total. A synchronous clear input returns every digit to zero. A one-cycle wrap pulse is raised when the total rolls over from 999 to 000. Several blocks can be chained by feeding that pulse, as the count line, into a block that holds the higher digits.

Top module: `decade_event_counter`

## Requirements
- R1: A high-to-low transition on `cnt_i` adds one to the total. The new total appears on `bcd_o` after the third rising clock edge that follows the input change. A low-to-high transition never changes the total.
- R2: Holding `cnt_i` low for many cycles adds exactly one, however long the low level lasts.
- R3: Each digit of `bcd_o` steps through 0 to 9 in binary-coded decimal. The ones digit is bits 3:0, the tens digit is bits 7:4 and the hundreds digit is bits 11:8. A digit that wraps from 9 to 0 adds one to the next higher digit.
- R4: All digits of a new total change on the same clock edge. For example, 099 becomes 100 in a single cycle, with no intermediate value visible.
- R5: While `hold_i` is 1 at the edge where a detected transition would advance the counter, the total stays unchanged.
- R6: A transition detected while `hold_i` is 1 is discarded. Setting `hold_i` back to 0 afterwards does not add it.
- R7: While `clear_i` is 1, `bcd_o` is forced to 000 and `wrap_o` to 0. This takes precedence over a pending transition and over `hold_i`. A transition that is pending when the clear happens is not counted after the clear is released.
- R8: `wrap_o` is 1 for exactly one clock cycle when the total rolls from 999 to 000, in the same cycle that 000 first appears. At all other times it is 0, so N complete rollovers give exactly N pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all state updates on its rising edge |
| clear_i | input | 1 | Synchronous clear, active high |
| hold_i | input | 1 | Count hold, active high; keeps the current total |
| cnt_i | input | 1 | Count line, asynchronous to `clk_i`; counted on its falling transitions |
| bcd_o | output | 12 | Total as three BCD digits, ones digit in the lowest nibble |
| wrap_o | output | 1 | Registered one-cycle pulse on rollover from 999 to 000 |

## Verification
The embedded properties assume that `clear_i` and `hold_i` are synchronous to `clk_i`. They also assume that each level of `cnt_i` lasts longer than one clock period, so that the synchronizer resolves every transition. The stimulus meets both assumptions. It changes every input only on falling clock edges, and it keeps each level of the count line for at least three cycles. The hold level is set together with the falling transition and stays in place until after the advance edge. This lets the reference model decide, for every transition, whether it is counted or discarded.

// File: rtl/evt_cnt_pkg.sv
`timescale 1ns/1ps
package evt_cnt_pkg;
   localparam int unsigned DIGIT_W = 4;
   typedef logic [DIGIT_W-1:0] digit_t;
   localparam digit_t DIGIT_TOP  = 4'd9;
   localparam digit_t DIGIT_ZERO = 4'd0;
endpackage

// File: rtl/evt_edge_sync.sv
`timescale 1ns/1ps
module evt_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic line_i,
   output logic fall_o
);
   initial assert (STAGES >= 2) else $error("evt_edge_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              settled;

   // resetting to zero means a line that is already high after reset gives no spurious fall
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         prev_q  <= settled;
      end
   end

   assign settled = chain_q[STAGES-1];
   assign fall_o  = prev_q & ~settled;

   // R1 / R2: a detected transition lasts one cycle only
   a_r2_single_fall: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |=> !fall_o);
endmodule

// File: rtl/evt_decade.sv
`timescale 1ns/1ps
module evt_decade
   import evt_cnt_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_i,
   input  logic   adv_i,
   output digit_t val_o,
   output logic   wrap_o
);
   digit_t val_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)      val_q <= DIGIT_ZERO;
      else if (adv_i) val_q <= (val_q == DIGIT_TOP) ? DIGIT_ZERO : val_q + 1'b1;
   end

   assign val_o  = val_q;
   assign wrap_o = adv_i && (val_q == DIGIT_TOP);

   a_r3_digit_range: assert property (@(posedge clk_i) disable iff (rst_i)
      val_o <= DIGIT_TOP);
   a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      (adv_i && val_o == DIGIT_TOP) |=> val_o == DIGIT_ZERO);
   a_r3_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
      (adv_i && val_o != DIGIT_TOP) |=> val_o == $past(val_o) + 1'b1);
   a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(val_o));
endmodule

// File: rtl/decade_event_counter.sv
`timescale 1ns/1ps
module decade_event_counter
   import evt_cnt_pkg::*;
#(
   parameter int unsigned NUM_DECADES = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                           clk_i,
   input  logic                           clear_i,
   input  logic                           hold_i,
   input  logic                           cnt_i,
   output logic [NUM_DECADES*DIGIT_W-1:0] bcd_o,
   output logic                           wrap_o
);
   localparam int unsigned OUT_W = NUM_DECADES * DIGIT_W;

   initial assert (NUM_DECADES >= 1) else $error("decade_event_counter: need at least one decade");

   logic                 fall;
   logic                 step;
   logic [NUM_DECADES:0] adv;
   logic                 wrap_q;

   evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_i  (clear_i),
      .line_i (cnt_i),
      .fall_o (fall)
   );

   // a fall seen during hold is dropped here; the detector has already moved on
   assign step   = fall & ~hold_i;
   assign adv[0] = step;

   for (genvar g = 0; g < NUM_DECADES; g++) begin : g_dec
      digit_t d_val;
      evt_decade u_dec (
         .clk_i  (clk_i),
         .rst_i  (clear_i),
         .adv_i  (adv[g]),
         .val_o  (d_val),
         .wrap_o (adv[g+1])
      );
      assign bcd_o[g*DIGIT_W +: DIGIT_W] = d_val;
   end

   always_ff @(posedge clk_i) begin
      if (clear_i) wrap_q <= 1'b0;
      else         wrap_q <= adv[NUM_DECADES];
   end
   assign wrap_o = wrap_q;

   a_r5_hold_keeps: assert property (@(posedge clk_i) disable iff (clear_i)
      hold_i |=> $stable(bcd_o));
   a_r4_no_step_no_change: assert property (@(posedge clk_i) disable iff (clear_i)
      !fall |=> $stable(bcd_o));
   a_r8_wrap_one_cycle: assert property (@(posedge clk_i) disable iff (clear_i)
      wrap_o |=> !wrap_o);
   a_r8_wrap_at_zero: assert property (@(posedge clk_i) disable iff (clear_i)
      wrap_o |-> bcd_o == {OUT_W{1'b0}});
endmodule

// File: tb/decade_event_counter_bench.sv
`timescale 1ns/1ps
module decade_event_counter_bench;
   logic        clk = 1'b0;
   logic        clear_i = 1'b1;
   logic        hold_i = 1'b0;
   logic        cnt_i = 1'b1;
   logic [11:0] bcd_o;
   logic        wrap_o;

   int n_chk = 0;
   int n_bad = 0;
   int exp_total = 0;
   int exp_wraps = 0;
   int wraps_seen = 0;
   bit done = 0;

   always #4 clk = ~clk;

   decade_event_counter u_decade_event_counter (
      .clk_i(clk), .clear_i(clear_i), .hold_i(hold_i),
      .cnt_i(cnt_i), .bcd_o(bcd_o), .wrap_o(wrap_o)
   );

   always @(negedge clk) if (!clear_i && wrap_o) wraps_seen++;

   function automatic logic [11:0] to_bcd(int v);
      return {4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
   endfunction

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_bit(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // one full pulse: fall (hold level d), low lo cycles, rise, high hi cycles
   task automatic pulse(bit d, int lo, int hi);
      hold_i = d;
      cnt_i  = 1'b0;
      cyc(lo);
      if (!d) begin
         exp_total = exp_total + 1;
         if (exp_total % 1000 == 0) exp_wraps++;
      end
      hold_i = 1'b0;
      cnt_i  = 1'b1;
      cyc(hi);
   endtask

   task automatic do_clear();
      clear_i = 1'b1;
      cyc(3);
      clear_i = 1'b0;
      exp_total = 0;
      cyc(1);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      cyc(3);
      // R7: reset state
      chk("R7 reset digits", bcd_o, 12'h000);
      chk_bit("R7 reset wrap", wrap_o, 1'b0);
      clear_i = 1'b0;
      cyc(2);

      // R1: exact latency of a fall, then a rise leaves it alone
      cnt_i = 1'b0;
      cyc(2);
      chk("R1 before third edge", bcd_o, 12'h000);
      cyc(1);
      chk("R1 after third edge", bcd_o, 12'h001);
      // R2: long low level counts once
      cyc(20);
      chk("R2 long low", bcd_o, 12'h001);
      cnt_i = 1'b1;
      cyc(6);
      chk("R1 rise ignored", bcd_o, 12'h001);
      exp_total = 1;

      // R5 / R6: fall under hold, released later, not counted
      hold_i = 1'b1;
      cnt_i  = 1'b0;
      cyc(5);
      chk("R5 hold keeps total", bcd_o, to_bcd(exp_total));
      hold_i = 1'b0;
      cyc(5);
      chk("R6 dropped edge not added", bcd_o, to_bcd(exp_total));
      cnt_i = 1'b1;
      cyc(4);

      // random mix, R3 carries and R5 holds
      for (int i = 0; i < 300; i++) begin
         pulse(($urandom % 4) == 0, 3 + $urandom % 3, 3 + $urandom % 3);
         chk("R3 random total", bcd_o, to_bcd(exp_total));
      end

      // R4: 099 -> 100 in one edge
      do_clear();
      for (int i = 0; i < 99; i++) pulse(1'b0, 3, 3);
      chk("R3 at 099", bcd_o, 12'h099);
      cnt_i = 1'b0;
      cyc(2);
      chk("R4 still 099", bcd_o, 12'h099);
      cyc(1);
      chk("R4 jump to 100", bcd_o, 12'h100);
      cnt_i = 1'b1;
      exp_total = 100;
      cyc(4);

      // R8: rollover 999 -> 000
      for (int i = 100; i < 999; i++) pulse(1'b0, 3, 3);
      chk("R3 at 999", bcd_o, 12'h999);
      wraps_seen = 0;
      cnt_i = 1'b0;
      cyc(2);
      chk_bit("R8 no early wrap", wrap_o, 1'b0);
      cyc(1);
      chk("R8 rolled to 000", bcd_o, 12'h000);
      chk_bit("R8 wrap high", wrap_o, 1'b1);
      cyc(1);
      chk_bit("R8 wrap one cycle", wrap_o, 1'b0);
      cnt_i = 1'b1;
      cyc(4);
      n_chk++;
      if (wraps_seen != 1) begin
         n_bad++;
         $display("FAIL R8 pulse count: actual %0d expected 1", wraps_seen);
      end

      // R7: clear beats a pending fall and hold
      exp_total = 0;
      pulse(1'b0, 3, 3);
      cnt_i  = 1'b0;
      hold_i = 1'b1;
      cyc(1);
      clear_i = 1'b1;
      cyc(2);
      chk("R7 clear forces zero", bcd_o, 12'h000);
      chk_bit("R7 clear wrap low", wrap_o, 1'b0);
      clear_i = 1'b0;
      hold_i  = 1'b0;
      cyc(6);
      chk("R7 pending fall lost", bcd_o, 12'h000);
      cnt_i = 1'b1;
      cyc(4);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule